// File: doc/BRIEF.md
# Dual-Polynomial Bit Randomizer

This block whitens a serial transmit bitstream by XORing each data bit with the output of a pseudo-random generator. Two generators are available: a short 6-stage register and a long 15-stage register. A mode field picks one of them, or turns randomization off so that bits pass through unchanged. At the start of every burst a programmable seed is loaded, so a receiver that knows the seed can strip the pattern from the burst.

The seed arrives on two inputs, a low byte and a 7-bit high part. The long generator uses both. The short generator takes six bits from the high part only. A position bit, captured with the mode at burst start, is presented as an output. The surrounding datapath uses it to place this stage before or after its error-correction encoder. Preamble bits and the error-correction code itself are handled outside this block.

Top module: `dual_scrambler`

## Requirements
- R1: Mode 00 uses the 6-stage generator (x^6 + x^5 + 1). With state s, the feedback is fb = s[5] ^ s[4], the scrambled bit is data ^ fb, and the state becomes {s[4:0], fb}.
- R2: Mode 01 uses the 15-stage generator (x^15 + x^14 + 1). The feedback is fb = s[14] ^ s[13], the scrambled bit is data ^ fb, and the state becomes {s[13:0], fb}.
- R3: In modes 10 and 11 the output bit equals the input bit.
- R4: The 15-stage seed is {seed_hi_i[6:0], seed_lo_i[7:0]}, with seed_hi_i[6] as the MSB.
- R5: The 6-stage seed is {seed_hi_i[6:2], seed_hi_i[0]}. seed_hi_i[1] and seed_lo_i have no effect in mode 00.
- R6: A burst_start_i pulse loads both generators with their seeds. If valid_i is high in the same cycle, that bit is scrambled from the seed value and the generator advances once from the seed.
- R7: A generator advances only on cycles where valid_i is high and it is the selected one. Idle cycles inside a burst do not change the sequence.
- R8: data_o and valid_o are registered one cycle after data_i and valid_i. data_o holds its value while valid_i is low.
- R9: mode_i and pos_before_fec_i are captured only on burst_start_i. The captured mode applies to the bit in the start cycle. Changes to either input in the middle of a burst are ignored until the next burst start.
- R10: pre_fec_o shows the captured position bit (1 = randomize before the encoder, 0 = after), one cycle after the burst_start_i pulse.
- R11: During and after reset, data_o, valid_o and pre_fec_o are 0 and the captured mode is off, so bits pass through until the first burst start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Sequence select: 00 short, 01 long, 1x off |
| seed_lo_i | input | 8 | Low byte of the long seed |
| seed_hi_i | input | 7 | High part of the long seed; source of the short seed |
| pos_before_fec_i | input | 1 | Chain position: 1 before encoder, 0 after |
| burst_start_i | input | 1 | One-cycle pulse that starts a burst and loads the seed |
| valid_i | input | 1 | data_i carries a bit this cycle |
| data_i | input | 1 | Serial input bit |
| data_o | output | 1 | Scrambled bit, one cycle later |
| valid_o | output | 1 | data_o carries a new bit |
| pre_fec_o | output | 1 | Captured chain position |

## Verification
The bench compares the output against a bit-level model of both generators. It does this across bursts that contain idle gaps, so a design that stepped the generator on idle cycles would drift out of step after the first gap. Seed pairs that differ only in seed_hi_i[1] must give identical short sequences; mapping that bit into the short seed would make the two streams differ. Mode and position are changed in the middle of a burst, which catches a design that uses the live inputs instead of the values captured at burst start. A burst start that coincides with a valid bit, and one that does not, both check that the first bit is scrambled from the seed and not from the stale state.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned SHORT_W   = 6;
  localparam int unsigned LONG_W    = 15;
  localparam int unsigned SEED_LO_W = 8;
  localparam int unsigned SEED_HI_W = LONG_W - SEED_LO_W;

  typedef enum logic [1:0] {
    MODE_SHORT   = 2'b00,
    MODE_LONG    = 2'b01,
    MODE_OFF     = 2'b10,
    MODE_OFF_ALT = 2'b11
  } scr_mode_e;
endpackage

// File: rtl/scr_lfsr.sv
module scr_lfsr #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned TAP_HI = WIDTH - 1,
  parameter int unsigned TAP_LO = WIDTH - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] seed_i,
  output logic             fb_o
);
  logic [WIDTH-1:0] state_q, cur, nxt;

  // seed bypass lets the bit in the load cycle use the fresh seed
  always_comb begin
    cur  = load_i ? seed_i : state_q;
    fb_o = cur[TAP_HI] ^ cur[TAP_LO];
    nxt  = cur;
    if (step_i) nxt = {cur[WIDTH-2:0], fb_o};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                state_q <= '0;
    else if (load_i || step_i)  state_q <= nxt;
  end
endmodule

// File: rtl/scr_seed_map.sv
module scr_seed_map
  import scr_pkg::*;
(
  input  logic [SEED_LO_W-1:0] seed_lo_i,
  input  logic [SEED_HI_W-1:0] seed_hi_i,
  output logic [LONG_W-1:0]    seed_long_o,
  output logic [SHORT_W-1:0]   seed_short_o
);
  assign seed_long_o  = {seed_hi_i, seed_lo_i};
  // bit 1 of the high part is unused by the short generator
  assign seed_short_o = {seed_hi_i[SEED_HI_W-1:2], seed_hi_i[0]};
endmodule

// File: rtl/dual_scrambler.sv
module dual_scrambler
  import scr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           mode_i,
  input  logic [SEED_LO_W-1:0] seed_lo_i,
  input  logic [SEED_HI_W-1:0] seed_hi_i,
  input  logic                 pos_before_fec_i,
  input  logic                 burst_start_i,
  input  logic                 valid_i,
  input  logic                 data_i,
  output logic                 data_o,
  output logic                 valid_o,
  output logic                 pre_fec_o
);
  scr_mode_e            mode_q, eff_mode;
  logic [LONG_W-1:0]    seed_long;
  logic [SHORT_W-1:0]   seed_short;
  logic                 fb_short, fb_long, fb_sel;
  logic                 step_short, step_long;

  scr_seed_map u_seed_map (
    .seed_lo_i   (seed_lo_i),
    .seed_hi_i   (seed_hi_i),
    .seed_long_o (seed_long),
    .seed_short_o(seed_short)
  );

  always_comb begin
    eff_mode   = burst_start_i ? scr_mode_e'(mode_i) : mode_q;
    step_short = valid_i && (eff_mode == MODE_SHORT);
    step_long  = valid_i && (eff_mode == MODE_LONG);
  end

  scr_lfsr #(.WIDTH(SHORT_W)) u_lfsr_short (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(burst_start_i),
    .step_i(step_short),
    .seed_i(seed_short),
    .fb_o  (fb_short)
  );

  scr_lfsr #(.WIDTH(LONG_W)) u_lfsr_long (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(burst_start_i),
    .step_i(step_long),
    .seed_i(seed_long),
    .fb_o  (fb_long)
  );

  always_comb begin
    unique case (eff_mode)
      MODE_SHORT: fb_sel = fb_short;
      MODE_LONG:  fb_sel = fb_long;
      default:    fb_sel = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MODE_OFF;
      pre_fec_o <= 1'b0;
      valid_o   <= 1'b0;
      data_o    <= 1'b0;
    end else begin
      if (burst_start_i) begin
        mode_q    <= scr_mode_e'(mode_i);
        pre_fec_o <= pos_before_fec_i;
      end
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i ^ fb_sel;
    end
  end
endmodule

// File: rtl/dual_scrambler_chk.sv
module dual_scrambler_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       burst_start_i,
  input logic       data_i,
  input logic       data_o,
  input logic       valid_o,
  input logic       pre_fec_o,
  input logic [1:0] mode_q
);
  // R3
  off_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !burst_start_i && mode_q[1]) |=> (data_o == $past(data_i)));

  // R8
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R8
  valid_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R8
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));

  // R9
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_start_i |=> $stable(mode_q));

  // R10
  pos_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_start_i |=> $stable(pre_fec_o));
endmodule

bind dual_scrambler dual_scrambler_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .burst_start_i(burst_start_i),
  .data_i       (data_i),
  .data_o       (data_o),
  .valid_o      (valid_o),
  .pre_fec_o    (pre_fec_o),
  .mode_q       (mode_q)
);

// File: tb/dual_scrambler_tb.sv
`timescale 1ns/1ps
module dual_scrambler_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b10;
  logic [7:0] seed_lo_i = '0;
  logic [6:0] seed_hi_i = '0;
  logic       pos_before_fec_i = 1'b0;
  logic       burst_start_i = 1'b0;
  logic       valid_i = 1'b0;
  logic       data_i = 1'b0;
  logic       data_o, valid_o, pre_fec_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dual_scrambler dut_i (.*);

  // model state
  logic [1:0]  m_mode = 2'b10;
  logic [5:0]  m_s6 = '0;
  logic [14:0] m_s15 = '0;
  logic        e_d = 1'b0, e_v = 1'b0, e_p = 1'b0;

  // [48:47] mode [46:40] seed_hi [39:32] seed_lo [31:16] data [15:0] valid mask
  localparam logic [48:0] VEC [6] = '{
    {2'd0, 7'h5B, 8'h00, 16'hA5C3, 16'hFFFF},
    {2'd1, 7'h3A, 8'hC7, 16'h0F0F, 16'hFFFF},
    {2'd1, 7'h01, 8'h00, 16'hFFFF, 16'hF3DF},
    {2'd2, 7'h7F, 8'hFF, 16'h1234, 16'hFFFF},
    {2'd3, 7'h2C, 8'h11, 16'hBEEF, 16'hAAAB},
    {2'd0, 7'h00, 8'hFF, 16'h9999, 16'hFFFF}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic bs, input logic v, input logic d, input logic [1:0] md,
                     input logic pos, input logic [6:0] hi, input logic [7:0] lo, input string tag);
    logic [1:0] em;
    logic       fb;
    @(negedge clk_i);
    burst_start_i = bs; valid_i = v; data_i = d; mode_i = md;
    pos_before_fec_i = pos; seed_hi_i = hi; seed_lo_i = lo;
    em = bs ? md : m_mode;
    if (bs) begin
      m_mode = md; e_p = pos;
      m_s6  = {hi[6:2], hi[0]};
      m_s15 = {hi, lo};
    end
    e_v = v;
    if (v) begin
      if (em == 2'b00) begin
        fb = m_s6[5] ^ m_s6[4]; e_d = d ^ fb; m_s6 = {m_s6[4:0], fb};
      end else if (em == 2'b01) begin
        fb = m_s15[14] ^ m_s15[13]; e_d = d ^ fb; m_s15 = {m_s15[13:0], fb};
      end else e_d = d;
    end
    @(posedge clk_i);
    #1;
    chk(valid_o === e_v, "R8 valid_o", 32'(valid_o), 32'(e_v));
    chk(data_o === e_d, tag, 32'(data_o), 32'(e_d));
    chk(pre_fec_o === e_p, "R10 pre_fec_o", 32'(pre_fec_o), 32'(e_p));
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] cap_a, cap_b;
    string tag;
    repeat (3) @(posedge clk_i);
    #1;
    // R11 reset state
    chk(data_o === 1'b0 && valid_o === 1'b0 && pre_fec_o === 1'b0, "R11 reset outputs",
        {29'd0, data_o, valid_o, pre_fec_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R11 off until first burst: bits pass through
    cyc(0, 1, 1, 2'b00, 0, 7'h55, 8'h55, "R11 pass before burst");
    cyc(0, 1, 0, 2'b01, 0, 7'h55, 8'h55, "R11 pass before burst");
    cyc(0, 1, 1, 2'b00, 0, 7'h55, 8'h55, "R11 pass before burst");

    // table walk
    foreach (VEC[k]) begin
      case (VEC[k][48:47])
        2'd0: tag = "R1/R5/R7 short";
        2'd1: tag = "R2/R4/R7 long";
        default: tag = "R3 off";
      endcase
      for (int i = 0; i < 16; i++)
        cyc(i == 0, VEC[k][i], VEC[k][16+i], VEC[k][48:47], k[0],
            VEC[k][46:40], VEC[k][39:32], tag);
      cyc(0, 0, 0, VEC[k][48:47], k[0], VEC[k][46:40], VEC[k][39:32], "R7 idle tail");
    end

    // R6 load without valid, idle gap, then data
    cyc(1, 0, 0, 2'b01, 1, 7'h40, 8'h00, "R6 load only");
    cyc(0, 0, 0, 2'b01, 1, 7'h40, 8'h00, "R6 idle");
    for (int i = 0; i < 16; i++) cyc(0, 1, 1'(i % 3), 2'b01, 1, 7'h40, 8'h00, "R4/R6 long from seed");
    // R6 restart mid-stream reloads seed
    for (int i = 0; i < 8; i++) cyc(i == 0, 1, 1'(i & 1), 2'b01, 0, 7'h40, 8'h00, "R6 restart");

    // R5 seed bit 1 and low byte ignored in short mode
    cap_a = '0; cap_b = '0;
    for (int i = 0; i < 8; i++) begin
      cyc(i == 0, 1, 0, 2'b00, 0, 7'b1010101, 8'h00, "R5 seed A");
      cap_a = {cap_a[6:0], data_o};
    end
    for (int i = 0; i < 8; i++) begin
      cyc(i == 0, 1, 0, 2'b00, 0, 7'b1010111, 8'hE7, "R5 seed B");
      cap_b = {cap_b[6:0], data_o};
    end
    chk(cap_a === cap_b, "R5 unused seed bits", 32'(cap_b), 32'(cap_a));
    chk(cap_a !== 8'h00, "R1 short sequence nonzero", 32'(cap_a), 32'hFF);

    // R9 mode and position change mid-burst are ignored
    cyc(1, 1, 1, 2'b00, 1, 7'h33, 8'h00, "R9 start short");
    for (int i = 0; i < 10; i++) cyc(0, 1, 1'(i & 1), 2'b10, 0, 7'h0F, 8'h00, "R9 mid-burst change");
    for (int i = 0; i < 6; i++) cyc(i == 0, 1, 1, 2'b10, 0, 7'h0F, 8'h00, "R9 new burst off");

    @(negedge clk_i);
    valid_i = 1'b0; burst_start_i = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule